// File: doc/BRIEF.md
# SCSI Controller Transfer Counter

This block keeps the byte count of a DMA transfer for a SCSI protocol controller. Software programs a start count one byte at a time over a byte-wide register port. The current count is held separately and is what reads return. Writing a command byte that carries the DMA flag copies the start count into the current count. A zero start count stands for the largest transfer size. Which size that is depends on an extended-mode bit in a configuration register.

While a DMA command is active, the data path consumes bytes through a decrement port. The count never goes below zero. When it reaches zero from a nonzero value, a terminal-count flag is raised, and software clears it by writing any start-count byte. In extended mode, a read of the high count byte returns a fixed identification byte in place of the count. The current count leaves the block with one extra top bit. That bit holds the value 2^24, which the three byte registers cannot show.

Register map (3-bit address):
- 0, 1 and 2 are the low, middle and high count bytes. Writes go to the start count and reads return the current count.
- 3 is the command byte, and bit 7 is the DMA flag.
- 4 is the status register. Only bit 4, the terminal-count flag, is used.
- 5 is the configuration byte, and bit 6 selects extended mode.
- Reads of addresses 6 and 7 return zero.

Top module: `xfer_count_unit`

## Requirements
- R1: After reset, the current count, the start count, the terminal-count flag, DMA-active, the command byte and the configuration byte are all zero.
- R2: Reads of addresses 0, 1 and 2 return bits 7:0, 15:8 and 23:16 of the current count. `cur_count` gives all 25 bits, and a write to a count address does not change the current count.
- R3: Writing address 3 with bit 7 set sets DMA-active and, one cycle later, makes the current count equal to the 24-bit start count when that count is nonzero.
- R4: A DMA command with a zero start count loads 0x10000 when configuration bit 6 is clear, and 0x1000000 (bit 24 of `cur_count`, byte reads zero) when it is set.
- R5: A read of address 2 returns 0x12 when configuration bit 6 is set, and otherwise returns the current high count byte.
- R6: While DMA-active is set, a decrement request subtracts `dec_amt` from the current count. While it is clear, the request is ignored.
- R7: A decrement of an amount equal to or larger than the current count leaves the count at zero.
- R8: When the current count goes from nonzero to zero, the terminal-count flag is set. It reads as bit 4 of address 4.
- R9: A write to address 0, 1 or 2 clears the terminal-count flag, unless a decrement in the same cycle sets it.
- R10: Writing address 3 with bit 7 clear clears DMA-active and leaves the current count unchanged.
- R11: A decrement request in the same cycle as a command write is dropped.
- R12: Address 3 reads back the last command byte, and address 5 reads back the configuration byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| dec_valid | input | 1 | Decrement request from the data path |
| dec_amt | input | 25 | Number of bytes consumed |
| cur_count | output | 25 | Current count, including the overflow bit |
| tc_flag | output | 1 | Terminal-count flag |
| dma_active | output | 1 | DMA command in progress |

## Verification
The bench uses the default widths: a 24-bit count, a 16-bit short expansion and the 0x12 identification byte. With these values the 64K and 16M zero-count expansions both fit in a single cycle. A decrement amount as wide as the count can drain a 16M load in one step, or it can exceed a small count, so saturation is exercised. Random register writes and decrements run in both configuration modes against a bench-side model. Directed cases cover the same-cycle collisions between commands, start-count writes and terminal decrements.

// File: rtl/xfer_count_unit.sv
module xfer_count_unit #(
  parameter int CW       = 24,
  parameter int SHORT_W  = 16,
  parameter int AW       = 3,
  parameter logic [7:0] ID_BYTE = 8'h12,
  parameter int EXT_BIT  = 6,
  parameter int DMA_BIT  = 7,
  parameter int TC_BIT   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          dec_valid,
  input  logic [CW:0]   dec_amt,
  output logic [CW:0]   cur_count,
  output logic          tc_flag,
  output logic          dma_active
);
  localparam int NB = CW / 8;
  localparam logic [AW-1:0] A_CMD  = AW'(NB);
  localparam logic [AW-1:0] A_STAT = AW'(NB + 1);
  localparam logic [AW-1:0] A_CFG  = AW'(NB + 2);
  localparam logic [CW:0] BIG   = (CW+1)'(1) << CW;
  localparam logic [CW:0] SHORT = (CW+1)'(1) << SHORT_W;

  logic [CW-1:0] start_q;
  logic [CW:0]   cnt_q;
  logic [7:0]    cmd_q, cfg_q;
  logic          tc_q, dma_q;

  wire cmd_wr   = reg_wr && reg_addr == A_CMD;
  wire start_wr = reg_wr && reg_addr < AW'(NB);
  wire dec_go   = dec_valid && dma_q && !cmd_wr;
  wire dec_sat  = dec_amt >= cnt_q;
  wire dec_term = dec_go && dec_sat && cnt_q != '0;
  wire ext_mode = cfg_q[EXT_BIT];
  wire [CW:0] reload = (start_q != '0) ? {1'b0, start_q} : (ext_mode ? BIG : SHORT);

  assign cur_count  = cnt_q;
  assign tc_flag    = tc_q;
  assign dma_active = dma_q;

  for (genvar i = 0; i < NB; i++) begin : g_start
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) start_q[8*i +: 8] <= '0;
      else if (reg_wr && reg_addr == AW'(i)) start_q[8*i +: 8] <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmd_q <= '0;
      cfg_q <= '0;
      tc_q  <= 1'b0;
      dma_q <= 1'b0;
    end else begin
      if (dec_go) cnt_q <= dec_sat ? '0 : cnt_q - dec_amt;
      if (cmd_wr) begin
        cmd_q <= reg_wdata;
        dma_q <= reg_wdata[DMA_BIT];
        if (reg_wdata[DMA_BIT]) cnt_q <= reload;
      end
      if (reg_wr && reg_addr == A_CFG) cfg_q <= reg_wdata;
      if (dec_term) tc_q <= 1'b1;
      else if (start_wr) tc_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NB; i++)
      if (reg_addr == AW'(i)) reg_rdata = cnt_q[8*i +: 8];
    if (reg_addr == AW'(NB - 1) && ext_mode) reg_rdata = ID_BYTE;
    if (reg_addr == A_CMD)  reg_rdata = cmd_q;
    if (reg_addr == A_STAT) reg_rdata[TC_BIT] = tc_q;
    if (reg_addr == A_CFG)  reg_rdata = cfg_q;
  end

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && reg_wdata[DMA_BIT] && start_q != '0) |=> (cnt_q == {1'b0, $past(start_q)} && dma_q));

  // R4
  zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && reg_wdata[DMA_BIT] && start_q == '0) |=> (cnt_q == BIG || cnt_q == SHORT));

  // R8
  tc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) != '0 && cnt_q == '0) |-> tc_q);

  // R9
  tc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && !(dec_valid && dma_q && !cmd_wr && dec_amt >= cnt_q && cnt_q != '0)) |=> !tc_q);

  // R10
  nodma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !reg_wdata[DMA_BIT]) |=> (!dma_q && $stable(cnt_q)));

  // R6
  idle_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_q && !cmd_wr) |=> $stable(cnt_q));

  // R7
  sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dma_q && !cmd_wr && dec_amt >= cnt_q) |=> cnt_q == '0);
endmodule

// File: tb/xfer_count_unit_test.sv
module xfer_count_unit_test;
  localparam int CLK_NS = 10;
  localparam int CW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic dec_valid = 1'b0;
  logic [CW:0] dec_amt = '0, cur_count;
  logic tc_flag, dma_active;

  int tests = 0, fails = 0;

  logic [CW-1:0] m_start;
  logic [CW:0] m_cnt;
  logic [7:0] m_cmd, m_cfg;
  logic m_tc, m_dma;

  xfer_count_unit uut (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .dec_valid, .dec_amt, .cur_count, .tc_flag, .dma_active);

  always #(CLK_NS/2) clk = ~clk;

  initial begin
    #(CLK_NS * 150000);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt[7:0];
      3'd1: return m_cnt[15:8];
      3'd2: return m_cfg[6] ? 8'h12 : m_cnt[23:16];
      3'd3: return m_cmd;
      3'd4: return {3'b0, m_tc, 4'b0};
      3'd5: return m_cfg;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_start = '0; m_cnt = '0; m_cmd = '0; m_cfg = '0; m_tc = 0; m_dma = 0;
  endtask

  task automatic step(input logic w, input logic [2:0] a, input logic [7:0] d,
                      input logic dv, input logic [CW:0] amt);
    logic [CW:0] n_cnt = m_cnt;
    logic n_tc = m_tc, n_dma = m_dma;
    logic cmdw = w && a == 3'd3;
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d; dec_valid = dv; dec_amt = amt;
    if (dv && m_dma && !cmdw) begin
      if (amt >= m_cnt) begin
        n_cnt = '0;
        if (m_cnt != '0) n_tc = 1;
      end else n_cnt = m_cnt - amt;
    end
    if (w && a <= 3'd2) begin
      if (!(n_tc && !m_tc) && !(dv && m_dma && !cmdw && amt >= m_cnt && m_cnt != '0)) n_tc = 0;
      m_start[8*a +: 8] = d;
    end
    if (cmdw) begin
      m_cmd = d; n_dma = d[7];
      if (d[7]) n_cnt = (m_start != '0) ? {1'b0, m_start} : (m_cfg[6] ? 25'h1000000 : 25'h10000);
    end
    if (w && a == 3'd5) m_cfg = d;
    @(posedge clk);
    m_cnt = n_cnt; m_tc = n_tc; m_dma = n_dma;
    @(negedge clk);
    reg_wr = 0; dec_valid = 0;
  endtask

  task automatic check_all(input string req);
    chk(req, 32'(cur_count), 32'(m_cnt));
    chk(req, 32'(tc_flag), 32'(m_tc));
    chk(req, 32'(dma_active), 32'(m_dma));
  endtask

  task automatic check_rd(input string req, input logic [2:0] a);
    reg_addr = a; #1;
    chk(req, 32'(reg_rdata), 32'(exp_rd(a)));
  endtask

  task automatic load(input logic [23:0] v);
    step(1, 3'd0, v[7:0], 0, '0);
    step(1, 3'd1, v[15:8], 0, '0);
    step(1, 3'd2, v[23:16], 0, '0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    check_all("R1");
    for (int a = 0; a < 8; a++) check_rd("R1", 3'(a));

    // R2 start writes do not touch current count
    load(24'h123456);
    check_all("R2");
    chk("R2", 32'(cur_count), 32'h0);
    // R3 DMA command loads
    step(1, 3'd3, 8'h90, 0, '0);
    chk("R3", 32'(cur_count), 32'h123456);
    chk("R3", 32'(dma_active), 32'h1);
    check_rd("R2", 3'd0); check_rd("R2", 3'd1); check_rd("R2", 3'd2);
    check_rd("R12", 3'd3);
    // R6 decrement
    step(0, 3'd0, 0, 1, 25'h56);
    chk("R6", 32'(cur_count), 32'h123400);
    // R11 decrement dropped on command write
    step(1, 3'd3, 8'h80, 1, 25'h5);
    chk("R11", 32'(cur_count), 32'h123456);
    // R7 R8 saturating decrement sets TC
    step(0, 3'd0, 0, 1, 25'h1FFFFFF);
    chk("R7", 32'(cur_count), 32'h0);
    chk("R8", 32'(tc_flag), 32'h1);
    check_rd("R8", 3'd4);
    // R8 decrement at zero keeps TC, count zero
    step(0, 3'd0, 0, 1, 25'h3);
    check_all("R8");
    // R9 start write clears TC
    step(1, 3'd1, 8'h00, 0, '0);
    chk("R9", 32'(tc_flag), 32'h0);
    // R4 zero start expansions
    load(24'h0);
    step(1, 3'd3, 8'h81, 0, '0);
    chk("R4", 32'(cur_count), 32'h10000);
    step(1, 3'd5, 8'h40, 0, '0);
    check_rd("R12", 3'd5);
    step(1, 3'd3, 8'h81, 0, '0);
    chk("R4", 32'(cur_count), 32'h1000000);
    reg_addr = 3'd0; #1; chk("R4", 32'(reg_rdata), 32'h0);
    reg_addr = 3'd1; #1; chk("R4", 32'(reg_rdata), 32'h0);
    // R5 id byte
    check_rd("R5", 3'd2);
    chk("R5", 32'(reg_rdata), 32'h12);
    // R9 terminal decrement wins over same-cycle start write
    step(1, 3'd0, 8'h07, 1, 25'h1000000);
    chk("R9", 32'(tc_flag), 32'h1);
    chk("R7", 32'(cur_count), 32'h0);
    // R10 non-DMA command
    load(24'h000010);
    step(1, 3'd3, 8'h80, 0, '0);
    step(1, 3'd3, 8'h01, 0, '0);
    chk("R10", 32'(dma_active), 32'h0);
    chk("R10", 32'(cur_count), 32'h10);
    // R6 decrement ignored while idle
    step(0, 3'd0, 0, 1, 25'h4);
    chk("R6", 32'(cur_count), 32'h10);
    step(1, 3'd5, 8'h00, 0, '0);
    check_rd("R5", 3'd2);

    // random mix (R2 R3 R6 R7 R8 R9 R10)
    for (int i = 0; i < 600; i++) begin
      int k = int'($urandom_range(0, 9));
      logic [CW:0] amt = ($urandom_range(0, 3) == 0) ? 25'($urandom) : 25'($urandom_range(0, 300));
      if (k < 3) step(1, 3'(k), 8'($urandom_range(0, 3) == 0 ? 0 : $urandom), $urandom_range(0, 1) == 1, amt);
      else if (k == 3) step(1, 3'd3, 8'($urandom), $urandom_range(0, 1) == 1, amt);
      else if (k == 4) step(1, 3'd5, ($urandom_range(0, 1) == 1) ? 8'h40 : 8'h00, 0, '0);
      else step(0, 3'd0, 0, 1, amt);
      check_all("R6 R8 rand");
      check_rd("R2 R5 rand", 3'($urandom_range(0, 7)));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule